// File: doc/BRIEF.md
# System Clock Source Select and Prescaler Tree

This block models, in clock-enable form, how a microcontroller derives its system, bus and timer clocks. Everything runs on one fast reference clock. Each oscillator source arrives as a single-cycle tick strobe in that domain. Every derived clock leaves the block as a single-cycle tick strobe as well.

The derived domains are formed in this order:

- The internal RC strobe is divided by a power of two to give a divided internal tick.
- A five-way selector picks the system tick from that divided tick, the fast external tick, the PLL output tick, the slow internal tick or the slow external tick.
- The system tick is divided to give the AHB tick.
- A fixed divide-by-eight of the AHB tick gives an auxiliary tick.
- The AHB tick is divided again to give the APB tick.
- A timer tick runs at the APB rate, or at twice that rate when the APB divider is above one.

Software-style writes set the source and the three dividers. Each write carries the divisor value itself. A write that is not a legal power of two is dropped. Every change waits for the next boundary of the output it affects, so no tick interval is ever cut short. A status output shows which source actually drives the system tick.

Top module: `sysclk_tick_tree`

## Requirements
- R1: After reset the source select is code 0 and all three programmable dividers are 1. While reset is asserted every tick output and `active_src` are 0. After release, each internal RC strobe yields one tick on `tick_rcdiv`, `tick_sys`, `tick_ahb`, `tick_apb` and `tick_tmr`.
- R2: A write to address 1 with a divisor D in {1,2,4,...,128} makes `tick_rcdiv` pulse once per D internal RC strobes.
- R3: A write to address 0 selects the system source by code: 0 divided internal, 1 fast external, 2 PLL output, 3 slow internal, 4 slow external. `tick_sys` then follows that source one for one, and `active_src` equals the code.
- R4: A write to address 2 with D in {1,2,...,512} makes `tick_ahb` pulse once per D system ticks, one cycle after the system tick that completes the count.
- R5: `tick_ahb8` pulses once per eight AHB ticks, one cycle after the AHB tick that completes the count.
- R6: A write to address 3 with D in {1,2,4,8,16} makes `tick_apb` pulse once per D AHB ticks, one cycle after the AHB tick that completes the count.
- R7: `tick_tmr` equals `tick_apb` when the APB divisor is 1. For any other APB divisor it pulses twice per APB period, and every APB tick is also a timer tick.
- R8: A divider write whose value is zero, has more than one bit set, or exceeds that divider's maximum is ignored. So is a select write above 4. The previous setting stays in force.
- R9: A new divider setting takes effect only when the current output period ends. The interval that is running at the time of the write completes at its old length.
- R10: After a select write, the system tick keeps following the old source, and `active_src` keeps the old code, until the new source's first tick. That tick is the first system tick of the new source. `active_src` changes only in a cycle that carries a system tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register: 0 select, 1 internal divider, 2 AHB divider, 3 APB divider |
| cfg_wdata | input | 16 | Source code or divisor value |
| int_rc_tick | input | 1 | Internal fast RC oscillator strobe |
| ext_fast_tick | input | 1 | Fast external oscillator strobe |
| pll_r_tick | input | 1 | PLL system-output strobe |
| int_slow_tick | input | 1 | Slow internal oscillator strobe |
| ext_slow_tick | input | 1 | Slow external oscillator strobe |
| tick_rcdiv | output | 1 | Divided internal clock tick |
| tick_sys | output | 1 | System clock tick |
| tick_ahb | output | 1 | AHB clock tick |
| tick_ahb8 | output | 1 | AHB tick divided by eight |
| tick_apb | output | 1 | APB clock tick |
| tick_tmr | output | 1 | Timer clock tick |
| active_src | output | 3 | Code of the source currently driving the system tick |

## Verification
The hardest state to reach from the ports is a pending source switch that has not yet completed. When all sources tick freely, the new source ticks within a few cycles and the pending state vanishes. The bench therefore silences one source strobe and selects that source. It then checks that both status and system tick stay on the old source for dozens of cycles, and only after that re-enables the strobe and watches the switch land on its first tick. Boundary deferral of a divider change is reached by writing mid-period into a long AHB period and timing the intervals around the write. Random configurations are bounded so that every measured period fits in the counting window.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  localparam int NSRC   = 5;
  localparam int SEL_W  = 3;
  localparam int CFG_DW = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_RCDIV    = 3'd0,
    SRC_EXT_FAST = 3'd1,
    SRC_PLL_R    = 3'd2,
    SRC_INT_SLOW = 3'd3,
    SRC_EXT_SLOW = 3'd4
  } src_e;

  localparam logic [ADDR_W-1:0] REG_SEL  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_RC   = 2'd1;
  localparam logic [ADDR_W-1:0] REG_AHB  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_APB  = 2'd3;

  // legal divisor: exactly one bit set, at a position not above max_exp
  function automatic logic div_ok(input logic [CFG_DW-1:0] v, input int max_exp);
    int   ones;
    logic in_range;
    ones     = 0;
    in_range = 1'b1;
    for (int i = 0; i < CFG_DW; i++) begin
      if (v[i]) begin
        ones++;
        if (i > max_exp) in_range = 1'b0;
      end
    end
    return in_range && (ones == 1);
  endfunction

  // bit position of the set bit of a legal divisor
  function automatic int div_exp(input logic [CFG_DW-1:0] v);
    int e;
    e = 0;
    for (int i = 0; i < CFG_DW; i++) begin
      if (v[i]) e = i;
    end
    return e;
  endfunction
endpackage

// File: rtl/sysclk_cfg_regs.sv
`timescale 1ns/1ps
module sysclk_cfg_regs
  import sysclk_pkg::*;
#(
  parameter int RC_EXP_MAX  = 7,
  parameter int AHB_EXP_MAX = 9,
  parameter int APB_EXP_MAX = 4,
  parameter int EW          = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output src_e              sel_req,
  output logic [EW-1:0]     rc_exp,
  output logic [EW-1:0]     ahb_exp,
  output logic [EW-1:0]     apb_exp
);
  logic          sel_ok;
  logic          rc_ok;
  logic          ahb_ok;
  logic          apb_ok;
  logic [EW-1:0] wr_exp;

  always_comb begin
    sel_ok = (cfg_wdata < CFG_DW'(NSRC));
    rc_ok  = div_ok(cfg_wdata, RC_EXP_MAX);
    ahb_ok = div_ok(cfg_wdata, AHB_EXP_MAX);
    apb_ok = div_ok(cfg_wdata, APB_EXP_MAX);
    wr_exp = EW'(div_exp(cfg_wdata));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_req <= SRC_RCDIV;
      rc_exp  <= '0;
      ahb_exp <= '0;
      apb_exp <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_SEL: if (sel_ok) sel_req <= src_e'(cfg_wdata[SEL_W-1:0]);
        REG_RC:  if (rc_ok)  rc_exp  <= wr_exp;
        REG_AHB: if (ahb_ok) ahb_exp <= wr_exp;
        REG_APB: if (apb_ok) apb_exp <= wr_exp;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_div_stage.sv
`timescale 1ns/1ps
module sysclk_div_stage #(
  parameter int MAX_EXP = 9,
  parameter int EW      = 4,
  parameter bit TWIN    = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_tick,
  input  logic [EW-1:0] req_exp,
  output logic          tick_o
);
  localparam int CW = MAX_EXP + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] ratio;
  logic [EW-1:0] cur_exp;
  logic          at_end;
  logic          at_mid;

  assign ratio  = CW'(1) << cur_exp;
  assign at_end = (cnt == ratio - CW'(1));

  generate
    if (TWIN) begin : g_twin
      assign at_mid = (cur_exp != '0) && (cnt == (ratio >> 1) - CW'(1));
    end else begin : g_plain
      assign at_mid = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_exp <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= in_tick && (at_end || at_mid);
      if (in_tick) begin
        if (at_end) begin
          cnt     <= '0;
          cur_exp <= req_exp;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sysclk_src_mux.sv
`timescale 1ns/1ps
module sysclk_src_mux
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_ticks,
  input  src_e            sel_req,
  output logic            sys_tick_o,
  output src_e            act_o
);
  logic pend_tick;
  logic do_switch;
  src_e act_nxt;

  always_comb begin
    pend_tick = src_ticks[sel_req];
    do_switch = (sel_req != act_o) && pend_tick;
    act_nxt   = do_switch ? sel_req : act_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o      <= SRC_RCDIV;
      sys_tick_o <= 1'b0;
    end else begin
      act_o      <= act_nxt;
      sys_tick_o <= src_ticks[act_nxt];
    end
  end
endmodule

// File: rtl/sysclk_tick_tree.sv
`timescale 1ns/1ps
module sysclk_tick_tree
  import sysclk_pkg::*;
#(
  parameter int RC_EXP_MAX  = 7,
  parameter int AHB_EXP_MAX = 9,
  parameter int APB_EXP_MAX = 4,
  parameter int AUX_EXP     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              int_rc_tick,
  input  logic              ext_fast_tick,
  input  logic              pll_r_tick,
  input  logic              int_slow_tick,
  input  logic              ext_slow_tick,
  output logic              tick_rcdiv,
  output logic              tick_sys,
  output logic              tick_ahb,
  output logic              tick_ahb8,
  output logic              tick_apb,
  output logic              tick_tmr,
  output logic [SEL_W-1:0]  active_src
);
  localparam int EW = $clog2(AHB_EXP_MAX + 1);

  src_e            sel_req;
  src_e            act_sel;
  logic [EW-1:0]   rc_exp;
  logic [EW-1:0]   ahb_exp;
  logic [EW-1:0]   apb_exp;
  logic [NSRC-1:0] src_ticks;

  sysclk_cfg_regs #(
    .RC_EXP_MAX (RC_EXP_MAX),
    .AHB_EXP_MAX(AHB_EXP_MAX),
    .APB_EXP_MAX(APB_EXP_MAX),
    .EW         (EW)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .sel_req  (sel_req),
    .rc_exp   (rc_exp),
    .ahb_exp  (ahb_exp),
    .apb_exp  (apb_exp)
  );

  sysclk_div_stage #(.MAX_EXP(RC_EXP_MAX), .EW(EW), .TWIN(1'b0)) u_rcdiv (
    .clk(clk), .rst(rst), .in_tick(int_rc_tick), .req_exp(rc_exp), .tick_o(tick_rcdiv)
  );

  // vector position equals the select code
  assign src_ticks = {ext_slow_tick, int_slow_tick, pll_r_tick, ext_fast_tick, tick_rcdiv};

  sysclk_src_mux u_mux (
    .clk       (clk),
    .rst       (rst),
    .src_ticks (src_ticks),
    .sel_req   (sel_req),
    .sys_tick_o(tick_sys),
    .act_o     (act_sel)
  );

  assign active_src = act_sel;

  sysclk_div_stage #(.MAX_EXP(AHB_EXP_MAX), .EW(EW), .TWIN(1'b0)) u_ahb (
    .clk(clk), .rst(rst), .in_tick(tick_sys), .req_exp(ahb_exp), .tick_o(tick_ahb)
  );

  sysclk_div_stage #(.MAX_EXP(AUX_EXP), .EW(EW), .TWIN(1'b0)) u_ahb8 (
    .clk(clk), .rst(rst), .in_tick(tick_ahb), .req_exp(EW'(AUX_EXP)), .tick_o(tick_ahb8)
  );

  sysclk_div_stage #(.MAX_EXP(APB_EXP_MAX), .EW(EW), .TWIN(1'b0)) u_apb (
    .clk(clk), .rst(rst), .in_tick(tick_ahb), .req_exp(apb_exp), .tick_o(tick_apb)
  );

  // lockstep copy of the APB counter that also fires at mid-period
  sysclk_div_stage #(.MAX_EXP(APB_EXP_MAX), .EW(EW), .TWIN(1'b1)) u_tmr (
    .clk(clk), .rst(rst), .in_tick(tick_ahb), .req_exp(apb_exp), .tick_o(tick_tmr)
  );
endmodule

// File: rtl/sysclk_tick_tree_chk.sv
`timescale 1ns/1ps
module sysclk_tick_tree_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_sys,
  input logic       tick_ahb,
  input logic       tick_ahb8,
  input logic       tick_apb,
  input logic       tick_tmr,
  input logic [2:0] active_src
);
  // R7
  tmr_covers_apb_chk: assert property (@(posedge clk) disable iff (rst)
    tick_apb |-> tick_tmr);

  // R5
  ahb8_after_ahb_chk: assert property (@(posedge clk) disable iff (rst)
    tick_ahb8 |-> $past(tick_ahb));

  // R6
  apb_after_ahb_chk: assert property (@(posedge clk) disable iff (rst)
    tick_apb |-> $past(tick_ahb));

  // R4
  ahb_after_sys_chk: assert property (@(posedge clk) disable iff (rst)
    tick_ahb |-> $past(tick_sys));

  // R10
  switch_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_src) |-> tick_sys);

  // R3
  legal_src_chk: assert property (@(posedge clk) disable iff (rst)
    active_src <= 3'd4);
endmodule

bind sysclk_tick_tree sysclk_tick_tree_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_sys  (tick_sys),
  .tick_ahb  (tick_ahb),
  .tick_ahb8 (tick_ahb8),
  .tick_apb  (tick_apb),
  .tick_tmr  (tick_tmr),
  .active_src(active_src)
);

// File: tb/sysclk_tick_tree_bench.sv
`timescale 1ns/1ps
module sysclk_tick_tree_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        int_rc_tick = 1'b0;
  logic        ext_fast_tick = 1'b0;
  logic        pll_r_tick = 1'b0;
  logic        int_slow_tick = 1'b0;
  logic        ext_slow_tick = 1'b0;
  logic        tick_rcdiv, tick_sys, tick_ahb, tick_ahb8, tick_apb, tick_tmr;
  logic [2:0]  active_src;

  sysclk_tick_tree u_sysclk_tick_tree (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .int_rc_tick(int_rc_tick), .ext_fast_tick(ext_fast_tick), .pll_r_tick(pll_r_tick),
    .int_slow_tick(int_slow_tick), .ext_slow_tick(ext_slow_tick),
    .tick_rcdiv(tick_rcdiv), .tick_sys(tick_sys), .tick_ahb(tick_ahb),
    .tick_ahb8(tick_ahb8), .tick_apb(tick_apb), .tick_tmr(tick_tmr),
    .active_src(active_src)
  );

  always #2.5 clk = ~clk;

  // source strobe periods, indexed by select code (code 0 is fed by the RC strobe)
  int          per[5] = '{1, 2, 3, 5, 7};
  logic [4:0]  en = 5'b11111;
  int          cyc = 0;
  int          tot[6];      // rcdiv, sys, ahb, ahb8, apb, tmr
  int          dlt[6];
  int          ahb_prev = 0;
  int          ahb_last = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  initial begin
    foreach (tot[i]) tot[i] = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (tick_rcdiv) tot[0]++;
      if (tick_sys)   tot[1]++;
      if (tick_ahb) begin tot[2]++; ahb_prev = ahb_last; ahb_last = cyc; end
      if (tick_ahb8)  tot[3]++;
      if (tick_apb)   tot[4]++;
      if (tick_tmr)   tot[5]++;
      int_rc_tick   = en[0] && (cyc % per[0] == 0);
      ext_fast_tick = en[1] && (cyc % per[1] == 0);
      pll_r_tick    = en[2] && (cyc % per[2] == 0);
      int_slow_tick = en[3] && (cyc % per[3] == 0);
      ext_slow_tick = en[4] && (cyc % per[4] == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic window(input int n);
    int s[6];
    @(posedge clk);
    s = tot;
    repeat (n) @(posedge clk);
    foreach (dlt[i]) dlt[i] = tot[i] - s[i];
  endtask

  // periodic pulse of period p seen in a window of n cycles
  task automatic chk_rate(input string req, input int idx, input int p, input int n);
    chk((dlt[idx] * p + p >= n) && (dlt[idx] * p <= n + p), req, dlt[idx], n / p);
  endtask

  task automatic apply(input int src, input int rc, input int ahb, input int apb, input int settle);
    wr(2'd1, 1 << rc);
    wr(2'd2, 1 << ahb);
    wr(2'd3, 1 << apb);
    wr(2'd0, src);
    repeat (settle) @(posedge clk);
  endtask

  task automatic chk_all(input string tag, input int src, input int rc, input int ahb,
                         input int apb, input int n);
    int psys, pahb, papb, ptmr;
    psys = (src == 0) ? (1 << rc) : per[src];
    pahb = psys << ahb;
    papb = pahb << apb;
    ptmr = (apb == 0) ? papb : papb / 2;
    window(n);
    chk(active_src == 3'(src), {tag, " R3 status"}, int'(active_src), src);
    chk_rate({tag, " R2 rcdiv"}, 0, 1 << rc, n);
    chk_rate({tag, " R3 sys"}, 1, psys, n);
    chk_rate({tag, " R4 ahb"}, 2, pahb, n);
    chk_rate({tag, " R5 ahb8"}, 3, pahb * 8, n);
    chk_rate({tag, " R6 apb"}, 4, papb, n);
    chk_rate({tag, " R7 tmr"}, 5, ptmr, n);
  endtask

  task automatic wait_ahb(output bit seen);
    int c0, t;
    c0 = tot[2]; t = 0; seen = 1'b0;
    while (!seen && t < 2000) begin
      @(posedge clk);
      t++;
      if (tot[2] != c0) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int src, rc, ahb, apb, pahb, papb, gap, s0, t;
    bit seen;
    void'($urandom(32'd4711));

    // R1: reset state
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk({tick_rcdiv, tick_sys, tick_ahb, tick_ahb8, tick_apb, tick_tmr} == 6'b0,
        "R1 ticks in reset", int'({tick_rcdiv, tick_sys, tick_ahb, tick_ahb8, tick_apb, tick_tmr}), 0);
    chk(active_src == 3'd0, "R1 status in reset", int'(active_src), 0);
    rst = 1'b0;
    repeat (50) @(posedge clk);
    chk_all("R1 defaults", 0, 0, 0, 0, 512);

    // random configurations
    for (int it = 0; it < 12; it++) begin
      do begin
        src = $urandom % 5; rc = $urandom % 8; ahb = $urandom % 10; apb = $urandom % 5;
        pahb = ((src == 0) ? (1 << rc) : per[src]) << ahb;
        papb = pahb << apb;
      end while (pahb * 8 > 1024 || papb > 1024);
      apply(src, rc, ahb, apb, 3000);
      chk_all("rand", src, rc, ahb, apb, 4096);
    end

    // R8: illegal writes leave the configuration alone
    apply(1, 0, 2, 1, 1500);
    wr(2'd2, 3); wr(2'd2, 0); wr(2'd2, 1024); wr(2'd2, 6);
    wr(2'd3, 32); wr(2'd3, 5); wr(2'd1, 256); wr(2'd1, 12);
    wr(2'd0, 5); wr(2'd0, 7); wr(2'd0, 6);
    repeat (300) @(posedge clk);
    chk_all("R8 rejected", 1, 0, 2, 1, 2048);

    // R9: divider change waits for the running period to end
    apply(0, 0, 6, 0, 1500);
    wait_ahb(seen);
    repeat (10) @(posedge clk);
    wr(2'd2, 1);
    wait_ahb(seen);
    gap = ahb_last - ahb_prev;
    chk(seen && gap == 64, "R9 old interval kept", gap, 64);
    wait_ahb(seen);
    gap = ahb_last - ahb_prev;
    chk(seen && gap == 1, "R9 new interval", gap, 1);

    // R10: switch to a silent source stays pending
    apply(0, 0, 0, 0, 200);
    @(posedge clk);
    en[4] = 1'b0;
    wr(2'd0, 4);
    s0 = tot[1];
    repeat (40) @(posedge clk);
    chk(active_src == 3'd0, "R10 status held", int'(active_src), 0);
    chk(tot[1] - s0 >= 39, "R10 old source still drives", tot[1] - s0, 40);
    @(posedge clk);
    en[4] = 1'b1;
    t = 0;
    while (active_src != 3'd4 && t < 30) begin @(posedge clk); t++; end
    chk(active_src == 3'd4, "R10 switch completes", int'(active_src), 4);
    repeat (20) @(posedge clk);
    chk_all("R10 after switch", 4, 0, 0, 0, 1400);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule